// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes stereo PCM audio from a three-wire serial link (a bit clock, a word clock and one data line) and turns each stereo frame into two signed 24-bit parallel samples. Both samples appear together with a one-cycle valid strobe. The serial inputs are oversampled in the system clock domain: each line passes through a short synchronizer, and a data bit is taken on every detected rising edge of the bit clock. Data is MSB first and in two's complement.

A static 3-bit format code picks one of three justifications and, through that, one of several word lengths. A separate static input swaps which word-clock level is treated as the left channel. Every word is presented left-aligned at 24 bits, so a shorter word carries its sign bit at bit 23 and has zeros below its LSB.

A continuous-zero detector counts bit-clock edges since the last nonzero sample. When the count reaches a limit it drives an active-low flag. If the zero-mute enable is set, the same condition forces both sample outputs to zero in that cycle.

Top module: `aud_rx_top`

## Requirements
- R1: A data bit is taken from the data line on each rising edge of the bit clock, and the first bit of a word is its MSB.
- R2: With `lr_swap_i` low, the half-frame sent while the word clock is high is the left sample and the half-frame sent while it is low is the right sample. With `lr_swap_i` high, the two are exchanged.
- R3: Right-justified codes are 000 (16 bits), 001 (20 bits) and 010 (24 bits). The last bit before a word-clock transition is the LSB. Earlier bits beyond the word length are ignored. The word is output left-aligned with zeros below it.
- R4: Code 011 is 24-bit left-justified: the first bit after a word-clock transition is the MSB, and bits after the 24th are ignored.
- R5: Code 100 (16 bits) and code 101 (24 bits) are I2S: the MSB arrives one bit clock after the word-clock transition. Bits after the word are ignored, and the output is left-aligned with zero fill.
- R6: Codes 110 and 111 are reserved and produce no valid strobe.
- R7: `smp_valid_o` pulses for exactly one cycle after each right half-frame that follows a left half-frame. The pulse presents the left/right pair. A right half-frame with no left half-frame before it produces no pulse.
- R8: After `ZERO_LIMIT` bit-clock edges (default 65536) with no nonzero completed sample, `zero_n_o` goes low. It stays high before that point.
- R9: With `zmute_en_i` high, an asserted zero condition drives `mute_o` high and forces both sample outputs to zero. With `zmute_en_i` low, the outputs keep the last pair while `zero_n_o` still reports the condition.
- R10: A nonzero completed sample on either channel clears the zero count and releases `zero_n_o`. The count saturates, so the flag stays asserted however long the zero run lasts.
- R11: After reset the valid strobe is low, both sample outputs are zero, `zero_n_o` is high and `mute_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bck_i | input | 1 | Serial bit clock |
| lrck_i | input | 1 | Word clock at the sample rate |
| sdin_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 3 | Format code (see R3 to R6) |
| lr_swap_i | input | 1 | Reverses the word-clock level to channel mapping |
| zmute_en_i | input | 1 | Enables forcing zero output on a zero run |
| smp_left_o | output | 24 | Left sample, left-aligned two's complement |
| smp_right_o | output | 24 | Right sample, left-aligned two's complement |
| smp_valid_o | output | 1 | One-cycle pulse for a new sample pair |
| zero_n_o | output | 1 | Active-low continuous-zero flag |
| mute_o | output | 1 | High while the outputs are forced to zero |

## Verification
Every valid format code is run with both word-clock polarities and with random words. Half-frames are 24 or 32 bit clocks long and carry random junk in the unused slots. A receiver that counted from the wrong end of the half-frame, or that read the junk slots, therefore gives different words. Directed frames place the most negative and most positive short words at the sign boundary, which exposes faults in alignment and zero fill. The reserved codes and a leading unpaired right half-frame check that no strobe appears when none is due. Zero runs with the mute both on and off tell a flag-only response apart from forced outputs. A run long enough to pass the counter's wrap point, followed by a nonzero word, separates a saturating count from a wrapping one and confirms that the flag releases.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    localparam int SMP_W = 24;

    typedef enum logic [2:0] {
        FMT_RJ16  = 3'b000,
        FMT_RJ20  = 3'b001,
        FMT_RJ24  = 3'b010,
        FMT_LJ24  = 3'b011,
        FMT_I2S16 = 3'b100,
        FMT_I2S24 = 3'b101,
        FMT_RSV6  = 3'b110,
        FMT_RSV7  = 3'b111
    } fmt_e;

    // word length in bits selected by a format code
    function automatic logic [4:0] word_len(input logic [2:0] f);
        case (f)
            3'b000, 3'b100: return 5'd16;
            3'b001:         return 5'd20;
            default:        return 5'd24;
        endcase
    endfunction

    function automatic logic fmt_is_rj(input logic [2:0] f);
        return (f[2] == 1'b0) && (f[1:0] != 2'b11);
    endfunction

    function automatic logic fmt_reserved(input logic [2:0] f);
        return f[2] & f[1];
    endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bck_i,
    input  logic lrck_i,
    input  logic sdin_i,
    output logic bit_edge_o,
    output logic lr_o,
    output logic din_o
);

    typedef struct packed {
        logic [STAGES-1:0][2:0] pipe;
        logic                   bck_prev;
    } sync_st_t;

    sync_st_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.pipe[0] = {bck_i, lrck_i, sdin_i};
        for (int i = 1; i < STAGES; i++) begin
            sync_d.pipe[i] = sync_q.pipe[i-1];
        end
        sync_d.bck_prev = sync_q.pipe[STAGES-1][2];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign bit_edge_o = sync_q.pipe[STAGES-1][2] & ~sync_q.bck_prev;
    assign lr_o       = sync_q.pipe[STAGES-1][1];
    assign din_o      = sync_q.pipe[STAGES-1][0];

    // R1
    edge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_edge_o |=> !bit_edge_o);

endmodule

// File: rtl/aud_rx_deser.sv
module aud_rx_deser
    import aud_rx_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_edge_i,
    input  logic             lr_i,
    input  logic             din_i,
    input  logic [2:0]       fmt_i,
    input  logic             lr_swap_i,
    output logic [SMP_W-1:0] left_o,
    output logic [SMP_W-1:0] right_o,
    output logic             valid_o,
    output logic             nz_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             primed;
        logic             lr_prev;
        logic [CNT_W-1:0] cnt;
        logic [SMP_W-1:0] sr;
        logic [SMP_W-1:0] acc;
        logic [SMP_W-1:0] hold_l;
        logic             have_l;
        logic [SMP_W-1:0] out_l;
        logic [SMP_W-1:0] out_r;
        logic             valid;
        logic             nz;
    } des_st_t;

    des_st_t des_d, des_q;

    logic [SMP_W-1:0] word;
    logic [SMP_W-1:0] acc_base;
    logic             boundary;
    logic             was_left;
    logic             rj;
    logic             in_win;
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] off;
    logic [CNT_W-1:0] rel;
    logic [CNT_W-1:0] wlen;
    logic [4:0]       pos;

    always_comb begin
        des_d       = des_q;
        des_d.valid = 1'b0;
        des_d.nz    = 1'b0;

        rj   = fmt_is_rj(fmt_i);
        wlen = CNT_W'(word_len(fmt_i));
        off  = CNT_W'(fmt_i[2]);

        // word that ends at a word-clock transition
        case (fmt_i)
            3'b000:  word = {des_q.sr[15:0], 8'h00};
            3'b001:  word = {des_q.sr[19:0], 4'h0};
            default: word = rj ? des_q.sr : des_q.acc;
        endcase

        boundary = bit_edge_i && des_q.primed && (lr_i != des_q.lr_prev);
        was_left = des_q.lr_prev ^ lr_swap_i;
        idx      = boundary ? '0 : des_q.cnt;
        rel      = idx - off;
        in_win   = !rj && (idx >= off) && (rel < wlen);
        pos      = 5'd23 - rel[4:0];
        acc_base = boundary ? '0 : des_q.acc;

        if (bit_edge_i) begin
            des_d.primed  = 1'b1;
            des_d.lr_prev = lr_i;
            des_d.sr      = {des_q.sr[SMP_W-2:0], din_i};
            des_d.acc     = acc_base;
            if (in_win) begin
                des_d.acc[pos] = din_i;
            end
            des_d.cnt = (idx == CNT_MAX) ? CNT_MAX : idx + CNT_W'(1);

            if (boundary && !fmt_reserved(fmt_i)) begin
                des_d.nz = |word;
                if (was_left) begin
                    des_d.hold_l = word;
                    des_d.have_l = 1'b1;
                end else if (des_q.have_l) begin
                    des_d.out_l  = des_q.hold_l;
                    des_d.out_r  = word;
                    des_d.valid  = 1'b1;
                    des_d.have_l = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            des_q <= '0;
        end else begin
            des_q <= des_d;
        end
    end

    assign left_o  = des_q.out_l;
    assign right_o = des_q.out_r;
    assign valid_o = des_q.valid;
    assign nz_o    = des_q.nz;

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R6
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_reserved(fmt_i) && $stable(fmt_i)) |-> !valid_o);

endmodule

// File: rtl/aud_rx_zdet.sv
module aud_rx_zdet #(
    parameter int unsigned LIMIT = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_edge_i,
    input  logic nz_i,
    output logic flag_o
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CMAX = CW'(LIMIT);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } zd_st_t;

    zd_st_t zd_d, zd_q;

    always_comb begin
        zd_d = zd_q;
        if (nz_i) begin
            zd_d.cnt = '0;
        end else if (bit_edge_i && (zd_q.cnt != CMAX)) begin
            zd_d.cnt = zd_q.cnt + CW'(1);
        end
        zd_d.flag = (zd_d.cnt == CMAX);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zd_q <= '0;
        end else begin
            zd_q <= zd_d;
        end
    end

    assign flag_o = zd_q.flag;

    // R10
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !nz_i) |=> flag_o);

    // R10
    zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nz_i |=> !flag_o);

    // R8
    zero_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(bit_edge_i));

endmodule

// File: rtl/aud_rx_top.sv
module aud_rx_top
    import aud_rx_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter int          SLOT_CNT_W  = 6,
    parameter int unsigned ZERO_LIMIT  = 65536
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bck_i,
    input  logic        lrck_i,
    input  logic        sdin_i,
    input  logic [2:0]  fmt_i,
    input  logic        lr_swap_i,
    input  logic        zmute_en_i,
    output logic [23:0] smp_left_o,
    output logic [23:0] smp_right_o,
    output logic        smp_valid_o,
    output logic        zero_n_o,
    output logic        mute_o
);

    logic             bit_edge;
    logic             lr_s;
    logic             din_s;
    logic [SMP_W-1:0] pair_l;
    logic [SMP_W-1:0] pair_r;
    logic             nz_evt;
    logic             zflag;

    aud_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .bck_i      (bck_i),
        .lrck_i     (lrck_i),
        .sdin_i     (sdin_i),
        .bit_edge_o (bit_edge),
        .lr_o       (lr_s),
        .din_o      (din_s)
    );

    aud_rx_deser #(.CNT_W(SLOT_CNT_W)) u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_edge_i (bit_edge),
        .lr_i       (lr_s),
        .din_i      (din_s),
        .fmt_i      (fmt_i),
        .lr_swap_i  (lr_swap_i),
        .left_o     (pair_l),
        .right_o    (pair_r),
        .valid_o    (smp_valid_o),
        .nz_o       (nz_evt)
    );

    aud_rx_zdet #(.LIMIT(ZERO_LIMIT)) u_zdet (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_edge_i (bit_edge),
        .nz_i       (nz_evt),
        .flag_o     (zflag)
    );

    assign mute_o      = zflag & zmute_en_i;
    assign zero_n_o    = ~zflag;
    assign smp_left_o  = mute_o ? '0 : pair_l;
    assign smp_right_o = mute_o ? '0 : pair_r;

endmodule

// File: tb/aud_rx_top_tb_top.sv
`timescale 1ns/1ps
module aud_rx_top_tb_top;

    localparam int ZLIM = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bck = 1'b0;
    logic        lrck = 1'b0;
    logic        sdin = 1'b0;
    logic [2:0]  fmt = 3'b000;
    logic        lrsw = 1'b0;
    logic        zen = 1'b0;
    logic [23:0] smp_l, smp_r;
    logic        smp_v, zero_n, mute;

    int total = 0;
    int bad = 0;
    int nvalid = 0;
    bit mon_quiet = 1'b0;
    string cur_tag = "R3";
    logic [47:0] expq[$];

    always #10 clk = ~clk;

    aud_rx_top #(.ZERO_LIMIT(ZLIM)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bck_i       (bck),
        .lrck_i      (lrck),
        .sdin_i      (sdin),
        .fmt_i       (fmt),
        .lr_swap_i   (lrsw),
        .zmute_en_i  (zen),
        .smp_left_o  (smp_l),
        .smp_right_o (smp_r),
        .smp_valid_o (smp_v),
        .zero_n_o    (zero_n),
        .mute_o      (mute)
    );

    task automatic chk(input bit ok, input string msg, input logic [47:0] act, input logic [47:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", msg, act, exp);
        end
    endtask

    function automatic int wl(input logic [2:0] f);
        if (f == 3'b000 || f == 3'b100) return 16;
        if (f == 3'b001) return 20;
        return 24;
    endfunction

    function automatic logic [23:0] exp_word(input logic [2:0] f, input logic [23:0] raw);
        logic [23:0] m;
        m = 24'hFFFFFF << (24 - wl(f));
        return raw & m;
    endfunction

    // sample pair monitor (R7)
    always @(negedge clk) begin
        if (rst_n && smp_v) begin
            nvalid++;
            if (!mon_quiet) begin
                if (expq.size() == 0) begin
                    chk(1'b0, {cur_tag, " R7 unexpected pair strobe"}, {smp_l, smp_r}, 48'h0);
                end else begin
                    logic [47:0] e;
                    e = expq.pop_front();
                    chk({smp_l, smp_r} == e, {cur_tag, " R1 R2 sample pair"}, {smp_l, smp_r}, e);
                end
            end
        end
    end

    task automatic bit_tick(input logic lr, input logic d);
        @(negedge clk);
        lrck = lr;
        sdin = d;
        repeat (2) @(negedge clk);
        bck = 1'b1;
        repeat (2) @(negedge clk);
        bck = 1'b0;
    endtask

    task automatic ticks(input int n, input logic lr);
        for (int i = 0; i < n; i++) bit_tick(lr, 1'b0);
    endtask

    task automatic send_half(input logic lr, input logic [2:0] f, input int s, input logic [23:0] w);
        int wn;
        wn = wl(f);
        for (int t = 0; t < s; t++) begin
            logic b;
            b = 1'($urandom_range(0, 1));
            if (f[2] == 1'b0 && f[1:0] != 2'b11) begin
                if (t >= s - wn) b = w[23 - (t - (s - wn))];
            end else if (f == 3'b011) begin
                if (t < 24) b = w[23 - t];
            end else if (f == 3'b100 || f == 3'b101) begin
                if (t >= 1 && t <= wn) b = w[23 - (t - 1)];
            end
            bit_tick(lr, b);
        end
    endtask

    task automatic do_reset(input logic [2:0] f, input logic sw, input logic ze);
        rst_n = 1'b0;
        bck = 1'b0;
        sdin = 1'b0;
        fmt = f;
        lrsw = sw;
        zen = ze;
        lrck = sw;
        expq.delete();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        nvalid = 0;
    endtask

    task automatic burst(input logic [2:0] f, input logic sw, input int n, input int s,
                         input bit fixed, input logic [23:0] fl, input logic [23:0] fr,
                         input string tag);
        logic lv_l, lv_r;
        int   nexp;
        cur_tag = tag;
        do_reset(f, sw, 1'b0);
        lv_l = ~sw;
        lv_r = sw;
        nexp = 0;
        // unpaired leading right half-frame (R7)
        send_half(lv_r, f, s, 24'h3C3C3C);
        for (int i = 0; i < n; i++) begin
            logic [23:0] rl, rr, el, er;
            rl = fixed ? fl : 24'($urandom());
            rr = fixed ? fr : 24'($urandom());
            el = exp_word(f, rl);
            er = exp_word(f, rr);
            if (!(f[2] && f[1])) begin
                expq.push_back({el, er});
                nexp++;
            end
            send_half(lv_l, f, s, el);
            send_half(lv_r, f, s, er);
        end
        bit_tick(lv_l, 1'b0);
        bit_tick(lv_l, 1'b0);
        repeat (8) @(negedge clk);
        chk(nvalid == nexp && expq.size() == 0, {tag, " R7 pair count"}, 48'(nvalid), 48'(nexp));
    endtask

    task automatic zero_case(input logic ze);
        logic [23:0] x, y;
        x = 24'h5A5A5A;
        y = 24'h000100;
        cur_tag = "R8";
        do_reset(3'b011, 1'b0, ze);
        mon_quiet = 1'b1;
        send_half(1'b0, 3'b011, 32, 24'h0);
        send_half(1'b1, 3'b011, 32, x);
        send_half(1'b0, 3'b011, 32, 24'h0);
        ticks(400, 1'b1);
        repeat (6) @(negedge clk);
        chk(zero_n == 1'b1, "R8 flag idle before limit", 48'(zero_n), 48'h1);
        chk(smp_l == x && mute == 1'b0, "R9 pair shown before limit", {smp_l, 23'h0, mute}, {x, 24'h0});
        ticks(120, 1'b1);
        repeat (6) @(negedge clk);
        chk(zero_n == 1'b0, "R8 flag after limit", 48'(zero_n), 48'h0);
        chk(mute == ze, "R9 mute follows enable", 48'(mute), 48'(ze));
        chk(smp_l == (ze ? 24'h0 : x), "R9 forced or kept left output", 48'(smp_l), 48'(ze ? 24'h0 : x));
        ticks(600, 1'b1);
        repeat (6) @(negedge clk);
        chk(zero_n == 1'b0, "R10 count saturates", 48'(zero_n), 48'h0);
        send_half(1'b0, 3'b011, 32, y);
        bit_tick(1'b1, 1'b0);
        repeat (6) @(negedge clk);
        chk(zero_n == 1'b1 && mute == 1'b0, "R10 nonzero sample clears flag", {46'h0, zero_n, mute}, 48'h2);
        chk(smp_r == y && smp_l == 24'h0, "R10 pair after clear", {smp_l, smp_r}, {24'h0, y});
        mon_quiet = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'hC0FFEE));
        do_reset(3'b000, 1'b0, 1'b0);
        chk(smp_v == 1'b0 && smp_l == 24'h0 && smp_r == 24'h0 && zero_n == 1'b1 && mute == 1'b0,
            "R11 reset state", {smp_l, smp_r}, 48'h0);

        // random frames, every valid code, both polarities
        for (int f = 0; f < 6; f++) begin
            for (int sw = 0; sw < 2; sw++) begin
                int s;
                string tg;
                s = (f >= 4) ? 32 : ((($urandom() & 1) != 0) ? 32 : 24);
                tg = (f < 3) ? "R3" : ((f == 3) ? "R4" : "R5");
                burst(3'(f), 1'(sw), 3, s, 1'b0, 24'h0, 24'h0, {tg, (sw != 0) ? " R2 swapped" : " R2 normal"});
            end
        end

        // directed sign-boundary words
        burst(3'b000, 1'b0, 1, 32, 1'b1, 24'h800000, 24'h7FFF00, "R3 rj16 extremes");
        burst(3'b001, 1'b1, 1, 32, 1'b1, 24'h7FFFF0, 24'h800010, "R3 rj20 extremes");
        burst(3'b011, 1'b0, 1, 32, 1'b1, 24'h800001, 24'h7FFFFE, "R4 lj24 extremes");
        burst(3'b100, 1'b0, 1, 24, 1'b1, 24'h800000, 24'h000100, "R5 i2s16 short slot");
        burst(3'b101, 1'b1, 1, 32, 1'b1, 24'hFFFFFF, 24'h000001, "R5 i2s24 extremes");

        // reserved codes
        burst(3'b110, 1'b0, 2, 32, 1'b0, 24'h0, 24'h0, "R6 code 110");
        burst(3'b111, 1'b1, 2, 32, 1'b0, 24'h0, 24'h0, "R6 code 111");

        zero_case(1'b0);
        zero_case(1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule